// File: doc/BRIEF.md
# Offset Trim Calibration Controller

This block searches for the trim code that cancels the offset of one converter channel. It drives a trim code into the analog trim input and reads back a single comparator flag, which is high when the code is above the point that cancels the offset. A binary search starts in the middle of the code range. Each candidate code must settle for a fixed time before the flag is read. A final re-check then moves the code up by one if it is still low.

Software, or a sequencer, pulses `start_i` while the channel is not converting. The controller turns the channel off and raises calibration mode for the whole search. When the search ends it pulses `done_o`, drops calibration mode and gives the channel back its own enable. The code it found stays on `trim_code_o`. At any other time a user write can load any code directly, and the active code can always be read on `trim_code_o`.

The sequence runs as a state machine:
- IDLE --start accepted--> SETUP.
- SETUP loads the midpoint code and the first step, then goes --timer kicked--> SETTLE.
- SETTLE --timer expired--> STEP.
- STEP applies the next trial code and goes to SETTLE while trials remain. After the last trial it goes --last trial--> FIX_SETTLE.
- FIX_SETTLE --timer expired--> FIX.
- FIX applies the one-step correction and goes to FINISH.
- FINISH --always--> IDLE.

Top module: `trim_cal_ctrl`

## Requirements
- R1: After reset the trim code is 0x10, and `busy_o`, `done_o` and `cal_mode_o` are low.
- R2: A calibration loads code 0x10 with a step of 8 and then runs four trials. In each trial a high flag subtracts the step from the code and a low flag adds it, and the step is halved, so it goes 8, 4, 2, 1.
- R3: After the last trial the code is settled once more and the flag is read again. A low flag raises the code by one unless the code is already 0x1F, which is kept.
- R4: Every applied code settles for SETTLE_CYCLES = CLK_FREQ_MHZ × SETTLE_TIME_US clock cycles before the flag is read. A whole calibration therefore keeps `busy_o` high for exactly 5·SETTLE_CYCLES + 7 cycles.
- R5: While `busy_o` is high, `chan_en_o` is low and `cal_mode_o` is high. While `busy_o` is low, `chan_en_o` follows `chan_en_i` and `cal_mode_o` is low.
- R6: A start while `conv_busy_i` is high is refused: `busy_o` stays low and the trim code does not change.
- R7: `busy_o` rises in the cycle after an accepted start and stays high through the one-cycle `done_o` pulse. The code found remains on `trim_code_o` after `done_o`.
- R8: A start that arrives during a calibration is ignored. No second calibration follows the `done_o` pulse.
- R9: A user write while idle loads `user_code_i` into the trim code on the next cycle. A user write while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request |
| conv_busy_i | input | 1 | Channel is converting; calibration refused |
| cmp_flag_i | input | 1 | Comparator flag, high when the code is above the offset point |
| chan_en_i | input | 1 | Channel enable requested by configuration |
| user_wr_i | input | 1 | User trim write strobe |
| user_code_i | input | TRIM_W | User trim value |
| trim_code_o | output | TRIM_W | Active trim code, always readable |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cal_mode_o | output | 1 | Channel held in calibration mode |
| chan_en_o | output | 1 | Effective channel enable |

## Verification
The assertions check four things on every cycle:
- no flag is read before the code has been stable for the full settle time;
- the step register holds at most one set bit;
- a start during a search, or a start while the channel is converting, never opens a new search;
- the channel stays off while busy, a user write has no effect while busy, and a code at the top stays at the top.

The right result of a search for a given comparator threshold, including the final correction, can only be shown by the bench scenarios. The same holds for the exact length of a calibration and for the channel enable coming back after completion.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SETTLE,
        S_STEP,
        S_FIX_SETTLE,
        S_FIX,
        S_FINISH
    } cal_state_e;

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
    parameter int unsigned CYCLES = 10000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (kick_i) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

    // a fresh kick never expires on the next cycle (settle window, R4)
    generate
        if (CYCLES > 1) begin : g_quiet
            p_kick_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                kick_i |=> !expire_o);
        end
    endgenerate

endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg #(
    parameter int unsigned       TRIM_W   = 5,
    parameter logic [TRIM_W-1:0] RST_CODE = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cal_ld_i,
    input  logic [TRIM_W-1:0] cal_code_i,
    input  logic              lock_i,
    input  logic              user_wr_i,
    input  logic [TRIM_W-1:0] user_code_i,
    output logic [TRIM_W-1:0] code_o
);
    logic [TRIM_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q <= RST_CODE;
        end else if (cal_ld_i) begin
            code_q <= cal_code_i;
        end else if (user_wr_i && !lock_i) begin
            code_q <= user_code_i;
        end
    end

    assign code_o = code_q;

    p_user_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && !cal_ld_i) |=> $stable(code_o));

endmodule

// File: rtl/trim_cal_fsm.sv
module trim_cal_fsm
    import trim_cal_pkg::*;
#(
    parameter int unsigned TRIM_W        = 5,
    parameter int unsigned SETTLE_CYCLES = 10000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              conv_busy_i,
    input  logic              cmp_flag_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              tmr_expire_i,
    output logic              tmr_kick_o,
    output logic              ld_o,
    output logic [TRIM_W-1:0] ld_code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cal_mode_o
);
    localparam logic [TRIM_W-1:0] CODE_MID = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [TRIM_W-1:0] DELTA0   = {2'b01, {(TRIM_W-2){1'b0}}};
    localparam logic [TRIM_W-1:0] CODE_TOP = {TRIM_W{1'b1}};

    cal_state_e        state_q, state_d;
    logic [TRIM_W-1:0] delta_q;
    logic [TRIM_W-1:0] step_code;
    logic              last_trial;

    assign step_code  = cmp_flag_i ? (trim_i - delta_q) : (trim_i + delta_q);
    assign last_trial = (delta_q >> 1) == '0;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // step register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 delta_q <= '0;
        else if (state_q == S_SETUP) delta_q <= DELTA0;
        else if (state_q == S_STEP)  delta_q <= delta_q >> 1;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start_i && !conv_busy_i) state_d = S_SETUP;
            S_SETUP:      state_d = S_SETTLE;
            S_SETTLE:     if (tmr_expire_i) state_d = S_STEP;
            S_STEP:       state_d = last_trial ? S_FIX_SETTLE : S_SETTLE;
            S_FIX_SETTLE: if (tmr_expire_i) state_d = S_FIX;
            S_FIX:        state_d = S_FINISH;
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tmr_kick_o = 1'b0;
        ld_o       = 1'b0;
        ld_code_o  = trim_i;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        cal_mode_o = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy_o     = 1'b0;
                cal_mode_o = 1'b0;
            end
            S_SETUP: begin
                ld_o       = 1'b1;
                ld_code_o  = CODE_MID;
                tmr_kick_o = 1'b1;
            end
            S_SETTLE, S_FIX_SETTLE: begin
            end
            S_STEP: begin
                ld_o       = 1'b1;
                ld_code_o  = step_code;
                tmr_kick_o = 1'b1;
            end
            S_FIX: begin
                if (!cmp_flag_i && trim_i != CODE_TOP) begin
                    ld_o      = 1'b1;
                    ld_code_o = trim_i + 1'b1;
                end
            end
            S_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o     = 1'b0;
                cal_mode_o = 1'b0;
            end
        endcase
    end

    // checker state: cycles for which the applied code has been unchanged
    localparam int unsigned SCW = $clog2(SETTLE_CYCLES + 1);
    logic [TRIM_W-1:0] trim_seen_q;
    logic [SCW-1:0]    stable_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trim_seen_q <= '0;
            stable_q    <= '0;
        end else begin
            trim_seen_q <= trim_i;
            if (trim_i != trim_seen_q)                  stable_q <= '0;
            else if (stable_q != SCW'(SETTLE_CYCLES))   stable_q <= stable_q + 1'b1;
        end
    end

    p_settle_before_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_STEP || state_q == S_FIX) |-> (32'(stable_q) >= SETTLE_CYCLES - 1));

    p_step_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(delta_q));

    p_top_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_FIX && trim_i == CODE_TOP) |=> (trim_i == CODE_TOP));

    p_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_IDLE && conv_busy_i) |=> (state_q == S_IDLE));

    p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != S_IDLE) |=> (state_q != S_SETUP));

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl #(
    parameter int unsigned       TRIM_W         = 5,
    parameter int unsigned       CLK_FREQ_MHZ   = 200,
    parameter int unsigned       SETTLE_TIME_US = 50,
    parameter logic [TRIM_W-1:0] RST_CODE       = 5'h10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              conv_busy_i,
    input  logic              cmp_flag_i,
    input  logic              chan_en_i,
    input  logic              user_wr_i,
    input  logic [TRIM_W-1:0] user_code_i,
    output logic [TRIM_W-1:0] trim_code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cal_mode_o,
    output logic              chan_en_o
);
    localparam int unsigned SETTLE_CYCLES = CLK_FREQ_MHZ * SETTLE_TIME_US;

    logic              tmr_kick;
    logic              tmr_expire;
    logic              cal_ld;
    logic [TRIM_W-1:0] cal_code;
    logic              busy;
    logic              cal_mode;

    trim_cal_fsm #(
        .TRIM_W        (TRIM_W),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .conv_busy_i  (conv_busy_i),
        .cmp_flag_i   (cmp_flag_i),
        .trim_i       (trim_code_o),
        .tmr_expire_i (tmr_expire),
        .tmr_kick_o   (tmr_kick),
        .ld_o         (cal_ld),
        .ld_code_o    (cal_code),
        .busy_o       (busy),
        .done_o       (done_o),
        .cal_mode_o   (cal_mode)
    );

    trim_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .kick_i   (tmr_kick),
        .expire_o (tmr_expire)
    );

    trim_code_reg #(
        .TRIM_W   (TRIM_W),
        .RST_CODE (RST_CODE)
    ) u_code (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cal_ld_i    (cal_ld),
        .cal_code_i  (cal_code),
        .lock_i      (busy),
        .user_wr_i   (user_wr_i),
        .user_code_i (user_code_i),
        .code_o      (trim_code_o)
    );

    assign busy_o     = busy;
    assign cal_mode_o = cal_mode;
    assign chan_en_o  = chan_en_i && !cal_mode;

    p_chan_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (!chan_en_o && cal_mode_o));

endmodule

// File: tb/trim_cal_ctrl_bench.sv
module trim_cal_ctrl_bench;
    localparam int unsigned W      = 5;
    localparam int unsigned MHZ    = 4;
    localparam int unsigned US     = 5;
    localparam int unsigned NSET   = MHZ * US;
    localparam int unsigned LAT    = 5 * NSET + 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         conv_busy = 1'b0;
    logic         chan_en = 1'b1;
    logic         user_wr = 1'b0;
    logic [W-1:0] user_code = '0;
    logic [W-1:0] thr = '0;
    logic         cmp_flag;
    logic [W-1:0] trim;
    logic         busy, done, cal_mode, chan_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    // comparator model: flag high when code above threshold
    assign cmp_flag = (trim > thr);

    trim_cal_ctrl #(
        .TRIM_W (W), .CLK_FREQ_MHZ (MHZ), .SETTLE_TIME_US (US), .RST_CODE (5'h10)
    ) u_trim_cal_ctrl (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .conv_busy_i (conv_busy),
        .cmp_flag_i (cmp_flag), .chan_en_i (chan_en), .user_wr_i (user_wr),
        .user_code_i (user_code), .trim_code_o (trim), .busy_o (busy),
        .done_o (done), .cal_mode_o (cal_mode), .chan_en_o (chan_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] t);
        int c = 16;
        int d = 8;
        while (d != 0) begin
            c = (c > int'(t)) ? c - d : c + d;
            d = d / 2;
        end
        if (!(c > int'(t)) && c < 31) c = c + 1;
        return W'(c);
    endfunction

    // monitor: on each completion pulse compare against scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(trim == e, "R2/R3 final code", int'(trim), int'(e));
            end
        end
    end

    // driver: one calibration, optionally with mid-run user write and start
    task automatic run_cal(input logic [W-1:0] t, input bit inject);
        int cnt = 0;
        logic [W-1:0] fin;
        thr = t;
        exp_q.push_back(model(t));
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        while (busy) begin
            cnt++;
            if (cnt == 5) begin
                check(!chan_en_o && cal_mode, "R5 channel off in cal",
                      int'({chan_en_o, cal_mode}), 1);
            end
            if (inject && cnt == 10) begin
                user_wr = 1'b1; user_code = '0; start = 1'b1;
            end
            if (inject && cnt == 11) begin
                user_wr = 1'b0; start = 1'b0;
                check(trim != '0, "R9 user write ignored while busy", int'(trim), -1);
            end
            @(negedge clk);
        end
        check(cnt == LAT, "R4 calibration length", cnt, LAT);
        fin = trim;
        check(chan_en_o == chan_en && !cal_mode, "R5 channel restored",
              int'({chan_en_o, cal_mode}), int'({chan_en, 1'b0}));
        repeat (4) @(negedge clk);
        check(!busy && trim == fin, "R8 no second run, R7 code kept",
              int'({busy, trim}), int'({1'b0, fin}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(trim == 5'h10, "R1 reset code", int'(trim), 16);
        check(!busy && !done && !cal_mode, "R1 reset flags",
              int'({busy, done, cal_mode}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(chan_en_o == 1'b1, "R5 enable follows input idle", int'(chan_en_o), 1);

        // R9 user write while idle
        user_wr = 1'b1; user_code = 5'h07;
        @(negedge clk) user_wr = 1'b0;
        check(trim == 5'h07, "R9 user write idle", int'(trim), 7);

        // R6 start refused while converting
        conv_busy = 1'b1; start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!busy, "R6 refused busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(!busy && trim == 5'h07, "R6 trim untouched", int'(trim), 7);
        conv_busy = 1'b0;

        run_cal(5'd13, 1'b0);
        run_cal(5'd20, 1'b1);
        run_cal(5'd0,  1'b0);
        run_cal(5'd31, 1'b0);   // R3 saturation at top
        run_cal(5'd30, 1'b0);
        chan_en = 1'b0;
        run_cal(5'd5,  1'b0);
        check(exp_q.size() == 0, "R7 all completions seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule